// File: doc/BRIEF.md
# Thermal Sensor Scan Supervisor

This block scans a set of temperature sensor channels through a request/response converter port and keeps the latest code of each channel in a register. It compares each code with a shutdown threshold set for that channel. A channel whose code stays at or above its threshold for enough samples in a row raises a maskable interrupt. The same condition can also latch a shutdown request, which is sent to a GPIO-style pin or to a chip reset request line. Software programs it over a small memory-mapped register bus.

A scan round samples every channel in ascending order. Rounds are separated by a programmable idle interval counted in prescaled ticks. When the most recent sample of any channel is over its threshold, the block uses a shorter idle interval. Software can choose to store either the raw converter code or its 10-bit complement against 1024. Software also sets the active level of both shutdown outputs. Clearing the scan enable stops sampling. A block reset returns every register to zero.

Register word offsets: 0x04 control, 0x08 enables and routing, 0x0C pending, 0x20+4n data n, 0x40+4n threshold n, 0x60 interrupt sample count, 0x64 shutdown sample count, 0x68 normal interval, 0x6C hot interval.

Top module: `thermsup_top`

## Requirements
- R1: After reset every register reads 0, `irq` is 0, and both shutdown outputs sit at their inactive level. With control bit 8 at 0 that level is 1.
- R2: While control bit 0 is 1, each round requests channels 0 up to NUM_CH-1 in order. `adc_req` stays high with a stable `adc_chan` until `adc_valid` arrives. `adc_req` then drops for at least one cycle.
- R3: A round's first request rises exactly PER×TICK_DIV cycles after the previous round's final `adc_valid` edge. The same delay applies after the write that sets control bit 0. PER is the normal interval at 0x68, and a value of 0 acts as 1.
- R4: While any channel's latest stored code is at or above its threshold, the interval at 0x6C replaces the one at 0x68.
- R5: With control bit 1 at 0, data register n holds the converter code masked to 12 bits. With bit 1 at 1 it holds (1024 − code) masked to 10 bits.
- R6: A sample counts as over when its stored code is at or above the channel threshold. Each channel counts over samples in a row, and any sample below threshold clears the count.
- R7: Pending bit n sets on each sample where the count is at least the value at 0x60. `irq` is the OR of pending bit n AND enable bit n over all channels.
- R8: Writing 1 to pending bit n clears it, and a set in the same cycle wins. Pending bit 8 records that a shutdown has latched, and no write clears it.
- R9: When control bit 4+n is set and channel n's count reaches the value at 0x64, the shutdown latches. It drives `tshut_gpio` if enable bit 4+n is set and `tshut_rst` if enable bit 8+n is set. The latch holds until reset, even with scanning disabled.
- R10: Each shutdown output equals its latch when control bit 8 is 1 and the inverse of its latch when bit 8 is 0.
- R11: A write to 0x08 that sets both routing bits of one channel keeps only the reset route, bit 8+n.
- R12: Clearing control bit 0 drops `adc_req` within two cycles. No further sample is then stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| adc_req | output | 1 | Conversion request, held until valid |
| adc_chan | output | 2 | Channel being requested |
| adc_valid | input | 1 | Conversion result strobe |
| adc_code | input | 12 | Raw conversion code |
| irq | output | 1 | High-temperature interrupt |
| tshut_gpio | output | 1 | Shutdown output toward the pin |
| tshut_rst | output | 1 | Shutdown output toward the reset controller |

## Verification
The bench targets the over-count restart. A run broken by one cool sample has to start counting again. A design that only counts total over samples would raise pending one round too early. The bench measures the idle gap exactly in both the cool and the hot state. An off-by-one tick, or a design that ignores the hot interval, shows up as a wrong cycle count. It also checks that acknowledging pending bits leaves the shutdown flag alone, and that a shutdown latch survives a disable and follows a change in polarity. The exclusive routing write and the complement code with raw values above 1024 are checked as well.

// File: rtl/thermsup_pkg.sv
package thermsup_pkg;
    // register word indices (byte address >> 2)
    localparam logic [5:0] W_CTRL   = 6'h01;
    localparam logic [5:0] W_ENAB   = 6'h02;
    localparam logic [5:0] W_PEND   = 6'h03;
    localparam logic [5:0] W_DATA   = 6'h08;
    localparam logic [5:0] W_THR    = 6'h10;
    localparam logic [5:0] W_IDEB   = 6'h18;
    localparam logic [5:0] W_SDEB   = 6'h19;
    localparam logic [5:0] W_PER    = 6'h1A;
    localparam logic [5:0] W_PERHT  = 6'h1B;

    typedef enum logic [1:0] {SC_IDLE, SC_REQ, SC_GAP} scan_st_e;
endpackage

// File: rtl/thermsup_chan.sv
module thermsup_chan #(
    parameter int CODE_W = 12,
    parameter int DEB_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample,
    input  logic [CODE_W-1:0] code,
    input  logic [CODE_W-1:0] thr,
    input  logic [DEB_W-1:0]  int_deb,
    input  logic [DEB_W-1:0]  shut_deb,
    output logic              over_q,
    output logic              int_hit,
    output logic              shut_hit
);
    typedef struct packed {
        logic [DEB_W-1:0] cnt;
        logic             over;
    } chan_t;

    chan_t c_d, c_q;
    logic  is_over;
    logic [DEB_W-1:0] cnt_nx;

    always_comb begin
        c_d     = c_q;
        is_over = (code >= thr);
        if (!is_over)
            cnt_nx = '0;
        else if (&c_q.cnt)
            cnt_nx = c_q.cnt;
        else
            cnt_nx = c_q.cnt + DEB_W'(1);
        int_hit  = sample && is_over && (cnt_nx >= int_deb);
        shut_hit = sample && is_over && (cnt_nx >= shut_deb);
        if (sample) begin
            c_d.cnt  = cnt_nx;
            c_d.over = is_over;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign over_q = c_q.over;

    AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (sample && (code < thr)) |=> (c_q.cnt == '0 && !over_q)); // R6
endmodule

// File: rtl/thermsup_sched.sv
module thermsup_sched import thermsup_pkg::*; #(
    parameter int NUM_CH   = 4,
    parameter int CODE_W   = 12,
    parameter int PER_W    = 16,
    parameter int TICK_DIV = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      auto_en,
    input  logic                      qsel,
    input  logic                      hot,
    input  logic [PER_W-1:0]          per,
    input  logic [PER_W-1:0]          per_ht,
    input  logic                      adc_valid,
    input  logic [CODE_W-1:0]         adc_code,
    output logic                      adc_req,
    output logic [$clog2(NUM_CH)-1:0] adc_chan,
    output logic                      samp_valid,
    output logic [$clog2(NUM_CH)-1:0] samp_ch,
    output logic [CODE_W-1:0]         samp_code
);
    localparam int CH_W  = $clog2(NUM_CH);
    localparam int DIV_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

    typedef struct packed {
        scan_st_e         st;
        logic [CH_W-1:0]  ch;
        logic [DIV_W-1:0] div;
        logic [PER_W-1:0] cnt;
    } sched_t;

    sched_t s_d, s_q;
    logic [PER_W-1:0] limit;
    logic [9:0]       neg_code;

    always_comb begin
        s_d        = s_q;
        samp_valid = 1'b0;
        limit      = hot ? per_ht : per;
        if (!auto_en) begin
            s_d.st  = SC_IDLE;
            s_d.ch  = '0;
            s_d.div = '0;
            s_d.cnt = '0;
        end else begin
            case (s_q.st)
                SC_IDLE: begin
                    if (s_q.div == DIV_W'(TICK_DIV - 1)) begin
                        s_d.div = '0;
                        if (({1'b0, s_q.cnt} + (PER_W+1)'(1)) >= {1'b0, limit}) begin
                            s_d.cnt = '0;
                            s_d.ch  = '0;
                            s_d.st  = SC_REQ;
                        end else begin
                            s_d.cnt = s_q.cnt + PER_W'(1);
                        end
                    end else begin
                        s_d.div = s_q.div + DIV_W'(1);
                    end
                end
                SC_REQ: begin
                    if (adc_valid) begin
                        samp_valid = 1'b1;
                        if (s_q.ch == CH_W'(NUM_CH - 1)) begin
                            s_d.st  = SC_IDLE;
                            s_d.div = '0;
                            s_d.cnt = '0;
                        end else begin
                            s_d.st = SC_GAP;
                        end
                    end
                end
                SC_GAP: begin
                    s_d.ch = s_q.ch + CH_W'(1);
                    s_d.st = SC_REQ;
                end
                default: s_d.st = SC_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign neg_code  = 10'd0 - adc_code[9:0];
    assign samp_code = qsel ? CODE_W'(neg_code) : adc_code;
    assign samp_ch   = s_q.ch;
    assign adc_chan  = s_q.ch;
    assign adc_req   = (s_q.st == SC_REQ);

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (adc_req && !adc_valid && auto_en) |=> (adc_req && $stable(adc_chan))); // R2
    AST_REQ_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (adc_req && adc_valid) |=> !adc_req); // R2
endmodule

// File: rtl/thermsup_regs.sv
module thermsup_regs import thermsup_pkg::*; #(
    parameter int NUM_CH = 4,
    parameter int CODE_W = 12,
    parameter int DEB_W  = 8,
    parameter int PER_W  = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bus_en,
    input  logic                      bus_we,
    input  logic [7:0]                bus_addr,
    input  logic [31:0]               bus_wdata,
    output logic [31:0]               bus_rdata,
    input  logic                      samp_valid,
    input  logic [$clog2(NUM_CH)-1:0] samp_ch,
    input  logic [CODE_W-1:0]         samp_code,
    input  logic [NUM_CH-1:0]         int_hit,
    input  logic [NUM_CH-1:0]         shut_hit,
    output logic                      auto_en,
    output logic                      qsel,
    output logic [NUM_CH-1:0][CODE_W-1:0] thr,
    output logic [DEB_W-1:0]          int_deb,
    output logic [DEB_W-1:0]          shut_deb,
    output logic [PER_W-1:0]          per,
    output logic [PER_W-1:0]          per_ht,
    output logic                      irq,
    output logic                      tshut_gpio,
    output logic                      tshut_rst
);
    typedef struct packed {
        logic                          auto_en;
        logic                          qsel;
        logic [NUM_CH-1:0]             src_en;
        logic                          pol;
        logic [NUM_CH-1:0]             int_en;
        logic [NUM_CH-1:0]             gpio_rt;
        logic [NUM_CH-1:0]             rst_rt;
        logic [NUM_CH-1:0]             pend;
        logic                          sd_flag;
        logic                          lat_gpio;
        logic                          lat_rst;
        logic [NUM_CH-1:0][CODE_W-1:0] thr;
        logic [NUM_CH-1:0][CODE_W-1:0] data;
        logic [DEB_W-1:0]              int_deb;
        logic [DEB_W-1:0]              shut_deb;
        logic [PER_W-1:0]              per;
        logic [PER_W-1:0]              per_ht;
    } regs_t;

    regs_t r_d, r_q;
    logic [5:0] word;
    logic       wr;
    logic [NUM_CH-1:0] trig;
    logic       unused_bits;

    assign word        = bus_addr[7:2];
    assign wr          = bus_en && bus_we;
    assign unused_bits = ^{bus_wdata[31:PER_W], bus_addr[1:0]};
    assign trig        = shut_hit & r_q.src_en;

    always_comb begin
        r_d = r_q;
        // hardware updates
        for (int n = 0; n < NUM_CH; n++)
            if (samp_valid && samp_ch == $clog2(NUM_CH)'(n))
                r_d.data[n] = samp_code;
        r_d.lat_gpio = r_q.lat_gpio | (|(trig & r_q.gpio_rt));
        r_d.lat_rst  = r_q.lat_rst  | (|(trig & r_q.rst_rt));
        r_d.sd_flag  = r_q.sd_flag  | (|trig);
        // software writes
        if (wr) begin
            case (word)
                W_CTRL: begin
                    r_d.auto_en = bus_wdata[0];
                    r_d.qsel    = bus_wdata[1];
                    r_d.pol     = bus_wdata[8];
                    for (int n = 0; n < NUM_CH; n++)
                        r_d.src_en[n] = bus_wdata[4+n];
                end
                W_ENAB: begin
                    for (int n = 0; n < NUM_CH; n++) begin
                        r_d.int_en[n]  = bus_wdata[n];
                        r_d.rst_rt[n]  = bus_wdata[8+n];
                        r_d.gpio_rt[n] = bus_wdata[4+n] & ~bus_wdata[8+n];
                    end
                end
                W_PEND: begin
                    for (int n = 0; n < NUM_CH; n++)
                        if (bus_wdata[n]) r_d.pend[n] = 1'b0;
                end
                W_IDEB:  r_d.int_deb  = bus_wdata[DEB_W-1:0];
                W_SDEB:  r_d.shut_deb = bus_wdata[DEB_W-1:0];
                W_PER:   r_d.per      = bus_wdata[PER_W-1:0];
                W_PERHT: r_d.per_ht   = bus_wdata[PER_W-1:0];
                default: ;
            endcase
            for (int n = 0; n < NUM_CH; n++)
                if (word == W_THR + 6'(n))
                    r_d.thr[n] = bus_wdata[CODE_W-1:0];
        end
        // a new hit wins over an acknowledge in the same cycle
        r_d.pend = r_d.pend | int_hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        bus_rdata = '0;
        case (word)
            W_CTRL: begin
                bus_rdata[0] = r_q.auto_en;
                bus_rdata[1] = r_q.qsel;
                bus_rdata[8] = r_q.pol;
                for (int n = 0; n < NUM_CH; n++) bus_rdata[4+n] = r_q.src_en[n];
            end
            W_ENAB: begin
                for (int n = 0; n < NUM_CH; n++) begin
                    bus_rdata[n]   = r_q.int_en[n];
                    bus_rdata[4+n] = r_q.gpio_rt[n];
                    bus_rdata[8+n] = r_q.rst_rt[n];
                end
            end
            W_PEND: begin
                bus_rdata[8] = r_q.sd_flag;
                for (int n = 0; n < NUM_CH; n++) bus_rdata[n] = r_q.pend[n];
            end
            W_IDEB:  bus_rdata = 32'(r_q.int_deb);
            W_SDEB:  bus_rdata = 32'(r_q.shut_deb);
            W_PER:   bus_rdata = 32'(r_q.per);
            W_PERHT: bus_rdata = 32'(r_q.per_ht);
            default: ;
        endcase
        for (int n = 0; n < NUM_CH; n++) begin
            if (word == W_DATA + 6'(n)) bus_rdata = 32'(r_q.data[n]);
            if (word == W_THR + 6'(n))  bus_rdata = 32'(r_q.thr[n]);
        end
    end

    assign auto_en    = r_q.auto_en;
    assign qsel       = r_q.qsel;
    assign thr        = r_q.thr;
    assign int_deb    = r_q.int_deb;
    assign shut_deb   = r_q.shut_deb;
    assign per        = r_q.per;
    assign per_ht     = r_q.per_ht;
    assign irq        = |(r_q.pend & r_q.int_en);
    assign tshut_gpio = r_q.pol ? r_q.lat_gpio : ~r_q.lat_gpio;
    assign tshut_rst  = r_q.pol ? r_q.lat_rst  : ~r_q.lat_rst;

    AST_SD_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.sd_flag |=> r_q.sd_flag); // R8
    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.lat_gpio || r_q.lat_rst) |=> ($past(r_q.lat_gpio) <= r_q.lat_gpio && $past(r_q.lat_rst) <= r_q.lat_rst)); // R9
    AST_ROUTE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.gpio_rt & r_q.rst_rt) == '0); // R11
    AST_PEND_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (int_hit != '0) |=> ((r_q.pend & $past(int_hit)) == $past(int_hit))); // R7
endmodule

// File: rtl/thermsup_top.sv
module thermsup_top #(
    parameter int NUM_CH   = 4,
    parameter int CODE_W   = 12,
    parameter int DEB_W    = 8,
    parameter int PER_W    = 16,
    parameter int TICK_DIV = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bus_en,
    input  logic                      bus_we,
    input  logic [7:0]                bus_addr,
    input  logic [31:0]               bus_wdata,
    output logic [31:0]               bus_rdata,
    output logic                      adc_req,
    output logic [$clog2(NUM_CH)-1:0] adc_chan,
    input  logic                      adc_valid,
    input  logic [CODE_W-1:0]         adc_code,
    output logic                      irq,
    output logic                      tshut_gpio,
    output logic                      tshut_rst
);
    localparam int CH_W = $clog2(NUM_CH);

    logic                          auto_en, qsel, samp_valid;
    logic [CH_W-1:0]               samp_ch;
    logic [CODE_W-1:0]             samp_code;
    logic [NUM_CH-1:0][CODE_W-1:0] thr;
    logic [DEB_W-1:0]              int_deb, shut_deb;
    logic [PER_W-1:0]              per, per_ht;
    logic [NUM_CH-1:0]             over_v, int_hit, shut_hit;

    thermsup_sched #(.NUM_CH(NUM_CH), .CODE_W(CODE_W), .PER_W(PER_W), .TICK_DIV(TICK_DIV)) u_sched (
        .clk(clk), .rst_n(rst_n), .auto_en(auto_en), .qsel(qsel), .hot(|over_v),
        .per(per), .per_ht(per_ht), .adc_valid(adc_valid), .adc_code(adc_code),
        .adc_req(adc_req), .adc_chan(adc_chan), .samp_valid(samp_valid),
        .samp_ch(samp_ch), .samp_code(samp_code)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        thermsup_chan #(.CODE_W(CODE_W), .DEB_W(DEB_W)) u_chan (
            .clk(clk), .rst_n(rst_n),
            .sample(samp_valid && samp_ch == CH_W'(g)),
            .code(samp_code), .thr(thr[g]), .int_deb(int_deb), .shut_deb(shut_deb),
            .over_q(over_v[g]), .int_hit(int_hit[g]), .shut_hit(shut_hit[g])
        );
    end

    thermsup_regs #(.NUM_CH(NUM_CH), .CODE_W(CODE_W), .DEB_W(DEB_W), .PER_W(PER_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .samp_valid(samp_valid),
        .samp_ch(samp_ch), .samp_code(samp_code), .int_hit(int_hit), .shut_hit(shut_hit),
        .auto_en(auto_en), .qsel(qsel), .thr(thr), .int_deb(int_deb), .shut_deb(shut_deb),
        .per(per), .per_ht(per_ht), .irq(irq), .tshut_gpio(tshut_gpio), .tshut_rst(tshut_rst)
    );
endmodule

// File: tb/tb_thermsup_top.sv
`timescale 1ns/1ps
module tb_thermsup_top;
    localparam int TD = 4;
    localparam int ADC_LAT = 2;
    localparam int WD = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_en = 1'b0, bus_we = 1'b0;
    logic [7:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic adc_req, adc_valid = 1'b0;
    logic [1:0] adc_chan;
    logic [11:0] adc_code = '0;
    logic irq, tshut_gpio, tshut_rst;

    always #10 clk = ~clk;

    thermsup_top dut (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .adc_req(adc_req), .adc_chan(adc_chan),
        .adc_valid(adc_valid), .adc_code(adc_code), .irq(irq), .tshut_gpio(tshut_gpio),
        .tshut_rst(tshut_rst)
    );

    int errors = 0, checks = 0, cyc = 0;
    int codes[4];
    int lat = 0;
    // behavioural model state
    int m_ctrl, m_en, m_pend, m_p8, m_lg, m_lr, m_ideb, m_sdeb, m_per, m_perht;
    int m_thr[4], m_data[4], m_cnt[4];
    int m_nsamp, m_last;

    task automatic chk(string tag, int got, int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d (cycle %0d)", tag, got, exp, cyc);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    task automatic model_reset();
        m_ctrl = 0; m_en = 0; m_pend = 0; m_p8 = 0; m_lg = 0; m_lr = 0;
        m_ideb = 0; m_sdeb = 0; m_per = 0; m_perht = 0; m_nsamp = 0; m_last = 0;
        for (int i = 0; i < 4; i++) begin m_thr[i] = 0; m_data[i] = 0; m_cnt[i] = 0; end
    endtask

    function automatic int exp_read(int a);
        case (a)
            8'h04: return m_ctrl;
            8'h08: return m_en;
            8'h0C: return m_pend | (m_p8 << 8);
            8'h60: return m_ideb;
            8'h64: return m_sdeb;
            8'h68: return m_per;
            8'h6C: return m_perht;
            default: begin
                if (a >= 8'h20 && a < 8'h30) return m_data[(a - 8'h20) / 4];
                if (a >= 8'h40 && a < 8'h50) return m_thr[(a - 8'h40) / 4];
                return 0;
            end
        endcase
    endfunction

    task automatic step();
        bit req_pre = adc_req;
        int ch_pre = int'(adc_chan);
        bit v_in = adc_valid;
        int code_in = int'(adc_code);
        bit w_in = bus_en && bus_we;
        int a_in = int'(bus_addr);
        int d_in = int'(bus_wdata);
        int setm = 0;
        @(posedge clk); #1;
        cyc++;
        if (cyc >= WD) begin
            errors++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            summary();
        end
        if (!rst_n) model_reset();
        else begin
            if (v_in && req_pre && (m_ctrl & 1)) begin
                int st = (m_ctrl & 2) ? ((1024 - code_in) & 1023) : (code_in & 4095);
                bit ov = (st >= m_thr[ch_pre]);
                chk("R2 channel order", ch_pre, m_nsamp % 4);
                m_data[ch_pre] = st;
                m_cnt[ch_pre] = ov ? ((m_cnt[ch_pre] < 255) ? m_cnt[ch_pre] + 1 : 255) : 0;
                if (ov && m_cnt[ch_pre] >= m_ideb) setm = 1 << ch_pre;
                if (ov && m_cnt[ch_pre] >= m_sdeb && ((m_ctrl >> (4 + ch_pre)) & 1)) begin
                    m_p8 = 1;
                    if ((m_en >> (4 + ch_pre)) & 1) m_lg = 1;
                    if ((m_en >> (8 + ch_pre)) & 1) m_lr = 1;
                end
                m_nsamp++; m_last = cyc;
            end
            if (w_in) begin
                case (a_in)
                    8'h04: m_ctrl = d_in & 32'h1F3;
                    8'h08: m_en = (d_in & 32'hF) | ((d_in & ~(d_in >> 4)) & 32'hF0) | (d_in & 32'hF00);
                    8'h0C: m_pend = m_pend & ~(d_in & 15);
                    8'h60: m_ideb = d_in & 255;
                    8'h64: m_sdeb = d_in & 255;
                    8'h68: m_per = d_in & 65535;
                    8'h6C: m_perht = d_in & 65535;
                    default: if (a_in >= 8'h40 && a_in < 8'h50) m_thr[(a_in - 8'h40) / 4] = d_in & 4095;
                endcase
            end
            m_pend = m_pend | setm;
        end
        chk("R7 irq", int'(irq), ((m_pend & m_en & 15) != 0) ? 1 : 0);
        chk("R10 gpio out", int'(tshut_gpio), (m_ctrl & 32'h100) ? m_lg : 1 - m_lg);
        chk("R10 rst out", int'(tshut_rst), (m_ctrl & 32'h100) ? m_lr : 1 - m_lr);
        // converter responder
        if (adc_valid) adc_valid = 1'b0;
        else if (adc_req) begin
            lat++;
            if (lat >= ADC_LAT) begin
                adc_valid = 1'b1; adc_code = 12'(codes[adc_chan]); lat = 0;
            end
        end else lat = 0;
    endtask

    task automatic wr(int a, int d);
        bus_en = 1; bus_we = 1; bus_addr = 8'(a); bus_wdata = 32'(d);
        step();
        bus_en = 0; bus_we = 0;
    endtask

    task automatic rd(int a, output int v);
        bus_en = 1; bus_we = 0; bus_addr = 8'(a); #1;
        v = int'(bus_rdata); bus_en = 0;
    endtask

    task automatic rd_chk(string tag, int a, int exp);
        int v;
        rd(a, v);
        chk(tag, v, exp);
        chk({tag, " model"}, v, exp_read(a));
    endtask

    task automatic wait_samples(int n);
        int tgt = m_nsamp + n;
        while (m_nsamp < tgt) step();
    endtask

    task automatic gap_check(string tag, int ref_c, int exp);
        while (!adc_req) step();
        chk(tag, cyc - ref_c, exp);
    endtask

    initial begin
        int v, ref_c;
        bit seen;
        codes = '{100, 200, 300, 400};
        model_reset();
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R1 reset state
        rd_chk("R1 ctrl", 8'h04, 0);
        rd_chk("R1 enab", 8'h08, 0);
        rd_chk("R1 pend", 8'h0C, 0);
        rd_chk("R1 data0", 8'h20, 0);
        rd_chk("R1 thr3", 8'h4C, 0);
        rd_chk("R1 per", 8'h68, 0);
        chk("R1 irq", int'(irq), 0);
        chk("R1 gpio inactive", int'(tshut_gpio), 1);
        chk("R1 rst inactive", int'(tshut_rst), 1);

        for (int i = 0; i < 4; i++) wr(8'h40 + 4 * i, 4000);
        wr(8'h60, 2); wr(8'h64, 3); wr(8'h68, 5); wr(8'h6C, 2); wr(8'h08, 32'hF);
        wr(8'h04, 1); ref_c = cyc;
        gap_check("R3 interval after enable", ref_c, 5 * TD);
        wait_samples(4);
        rd_chk("R5 raw data0", 8'h20, 100);
        rd_chk("R5 raw data3", 8'h2C, 400);
        gap_check("R3 normal interval", m_last, 5 * TD);
        wait_samples(4);

        // R5 complement storage
        codes[3] = 1500;
        wr(8'h04, 3);
        wait_samples(8);
        rd_chk("R5 complement data0", 8'h20, 924);
        rd_chk("R5 complement data3 above 1024", 8'h2C, 548);
        codes[3] = 400;
        wr(8'h04, 1);
        wait_samples(8);

        // R6 R7 debounce and interrupt
        while (adc_req || (m_nsamp % 4) != 0) step();
        wr(8'h44, 150);
        wait_samples(4);
        rd_chk("R7 pend after one over sample", 8'h0C, 0);
        gap_check("R4 hot interval", m_last, 2 * TD);
        wait_samples(4);
        rd_chk("R7 pend after two over samples", 8'h0C, 2);
        chk("R7 irq high", int'(irq), 1);
        wr(8'h0C, 2);
        rd_chk("R8 pend cleared by one write", 8'h0C, 0);
        codes[1] = 100;
        wait_samples(4);
        rd_chk("R6 cool sample", 8'h0C, 0);
        gap_check("R4 back to normal interval", m_last, 5 * TD);
        codes[1] = 200;
        wait_samples(4);
        rd_chk("R6 count restarted", 8'h0C, 0);
        wait_samples(4);
        rd_chk("R6 second consecutive over", 8'h0C, 2);
        wr(8'h08, 32'hD);
        chk("R7 irq masked", int'(irq), 0);

        // R11 exclusive routing
        wr(8'h08, 32'h111);
        rd_chk("R11 reset route kept", 8'h08, 32'h101);

        // R9 R10 shutdown
        while (adc_req || (m_nsamp % 4) != 0) step();
        wr(8'h48, 250);
        wr(8'h08, 32'h040);
        wr(8'h04, 32'h141);
        chk("R10 gpio inactive high pol", int'(tshut_gpio), 0);
        chk("R10 rst inactive high pol", int'(tshut_rst), 0);
        wait_samples(8);
        chk("R9 no shutdown before count", int'(tshut_gpio), 0);
        wait_samples(4);
        chk("R9 gpio shutdown", int'(tshut_gpio), 1);
        chk("R9 rst not routed", int'(tshut_rst), 0);
        rd(8'h0C, v);
        chk("R8 shutdown flag set", (v >> 8) & 1, 1);
        wr(8'h0C, 32'h1FF);
        rd(8'h0C, v);
        chk("R8 shutdown flag survives ack", (v >> 8) & 1, 1);

        // R12 disable
        while (!adc_req) step();
        wr(8'h04, 32'h140);
        step();
        chk("R12 request dropped", int'(adc_req), 0);
        seen = 0;
        for (int i = 0; i < 200; i++) begin step(); if (adc_req) seen = 1; end
        chk("R12 no further requests", int'(seen), 0);
        rd_chk("R12 data unchanged", 8'h20, 100);
        chk("R9 latch held while disabled", int'(tshut_gpio), 1);
        wr(8'h04, 32'h040);
        chk("R10 latched active low", int'(tshut_gpio), 0);
        chk("R10 unlatched active low", int'(tshut_rst), 1);

        // reset clears everything
        rst_n = 1'b0; step(); step();
        rst_n = 1'b1; step();
        chk("R1 gpio after reset", int'(tshut_gpio), 1);
        rd_chk("R1 pend after reset", 8'h0C, 0);
        rd_chk("R1 ctrl after reset", 8'h04, 0);

        // R3 zero interval acts as one
        wr(8'h04, 1); ref_c = cyc;
        gap_check("R3 zero interval", ref_c, TD);
        wait_samples(4);
        summary();
    end
endmodule